// File: doc/BRIEF.md
# Programmable Period-Multiplying Time Stretcher

This block produces a delay that is a whole multiple of the period of the clock driving it. A start request loads an unsigned gain code. The block then counts rising edges of its period clock. When the programmed number of periods has passed, it raises a level output that marks the stretched edge, together with an end-of-conversion flag. Both stay high until the next start.

Two identical copies are normally used side by side, and both are built with the same code width. In the first copy, a temperature-dependent ring oscillator drives the period clock and the gain code scales its period into a sensing delay. In the second copy, a stable reference clock drives the period clock and the code is a set-point. A later timing comparator reads the two delays. The end-of-conversion flag is the signal that powers the oscillator and its bias down once the measurement is over.

A start is accepted on every edge, including while a count is still running. A code of zero is treated as a one-period request, so the counter never wraps around.

Top module: `period_stretcher`

## Requirements
- R1: While `rst` is sampled high, and on the first edge after it, `stretch_out` and `eoc` are low.
- R2: For a code N of 1 or more, `stretch_out` rises exactly N period-clock cycles after the edge that samples `start` high, so the delay equals N times the clock period.
- R3: A code of 0 gives the same delay as a code of 1: the output rises on the first edge after the start edge, and the counter does not wrap.
- R4: After `stretch_out` and `eoc` rise, they stay high until an edge that samples `start` high. That edge clears both of them.
- R5: A start sampled while a count is running discards that count. The new code is loaded, and the delay is measured from the new start edge.
- R6: With a fixed clock period, a larger code gives a strictly later output edge.
- R7: The full-scale code 2^CODE_W-1 (16383 with the default width of 14) gives a delay of 16383 periods with no overflow.
- R8: `eoc` and `stretch_out` change in the same cycle and always carry the same value.
- R9: Clock edges that arrive without any start after reset leave both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Period clock: the oscillator or the reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled on the rising edge of clk |
| code | input | CODE_W | Gain or set-point code, loaded on the start edge |
| stretch_out | output | 1 | Stretched delay edge, held high until the next start |
| eoc | output | 1 | End-of-conversion flag, used to gate the oscillator off |

## Verification
The assertions check several rules on every cycle. The count never rises except on a load. A start always clears the finished state, and the finished state holds until the next start. A running count that reaches its last period always ends in the finished state. Without a start, an idle block never raises its output.

Other behaviours can only be shown by the bench's scenarios. These are the absolute delay in nanoseconds at several clock periods, the code-0 and full-scale cases, and the restart during a count. They also include the ordering of delays for larger codes, which depends on the whole sequence of edges.

// File: rtl/stretch_pkg.sv
package stretch_pkg;

    localparam int DEFAULT_CODE_W = 14;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2
    } stretch_state_e;

    typedef struct packed {
        logic load;
        logic dec;
    } cnt_cmd_t;

    function automatic stretch_state_e next_state(
        input stretch_state_e cur,
        input logic           start,
        input logic           last
    );
        stretch_state_e nxt;
        nxt = cur;
        if (start) begin
            nxt = ST_COUNT;
        end else if (cur == ST_COUNT && last) begin
            nxt = ST_DONE;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/stretch_counter.sv
module stretch_counter
    import stretch_pkg::*;
#(
    parameter int CODE_W = DEFAULT_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  cnt_cmd_t          cmd,
    input  logic [CODE_W-1:0] load_val,
    output logic [CODE_W-1:0] cnt,
    output logic              last
);

    localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cmd.load) begin
            cnt <= load_val;
        end else if (cmd.dec) begin
            cnt <= cnt - ONE;
        end
    end

    // Codes 0 and 1 both end on the first counted edge.
    assign last = (cnt <= ONE);

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !cmd.load |=> cnt <= $past(cnt)); // R7

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> cnt == $past(load_val)); // R2

endmodule

// File: rtl/stretch_ctrl.sv
module stretch_ctrl
    import stretch_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     last,
    output cnt_cmd_t cmd,
    output logic     running,
    output logic     done
);

    stretch_state_e state_q;
    stretch_state_e state_d;

    always_comb begin
        state_d  = next_state(state_q, start, last);
        cmd.load = start;
        cmd.dec  = !start && (state_q == ST_COUNT) && !last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign running = (state_q == ST_COUNT);
    assign done    = (state_q == ST_DONE);

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start |=> !done); // R4

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done); // R4

    AST_TERM_FINISHES: assert property (@(posedge clk) disable iff (rst)
        running && last && !start |=> done); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !running && !done && !start |=> !done); // R9

endmodule

// File: rtl/period_stretcher.sv
module period_stretcher
    import stretch_pkg::*;
#(
    parameter int CODE_W = DEFAULT_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    output logic              stretch_out,
    output logic              eoc
);

    cnt_cmd_t          cmd;
    logic [CODE_W-1:0] cnt;
    logic              last;
    logic              running;
    logic              done;

    stretch_counter #(.CODE_W(CODE_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .load_val (code),
        .cnt      (cnt),
        .last     (last)
    );

    stretch_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .last    (last),
        .cmd     (cmd),
        .running (running),
        .done    (done)
    );

    assign stretch_out = done;
    assign eoc         = done;

    AST_RESET_LOW: assert property (@(posedge clk)
        $past(rst) |-> !stretch_out && !eoc); // R1

endmodule

// File: tb/period_stretcher_test.sv
`timescale 1ns/100ps
module period_stretcher_test;

    localparam int  CODE_W     = 14;
    localparam real CLK_PERIOD = 25.0;
    localparam int  WATCHDOG   = 190000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [CODE_W-1:0] code = '0;
    logic              stretch_out;
    logic              eoc;

    real   period = CLK_PERIOD;
    int    checks = 0;
    int    fails = 0;
    int    cycles = 0;
    string tag = "R1";

    bit    exp_done = 1'b0;
    bit    exp_active = 1'b0;
    int    remain = 0;
    real   t_start = 0.0;
    real   t_rise = 0.0;

    period_stretcher #(.CODE_W(CODE_W)) uut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .code        (code),
        .stretch_out (stretch_out),
        .eoc         (eoc)
    );

    initial forever begin
        #(period / 2.0) clk = ~clk;
    end

    // Behavioural reference: remaining periods and finished flag.
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            exp_done = 1'b0; exp_active = 1'b0; remain = 0;
        end else if (start) begin
            exp_active = 1'b1; exp_done = 1'b0;
            remain = (code == 0) ? 1 : int'(code);
            t_start = $realtime;
        end else if (exp_active) begin
            remain--;
            if (remain == 0) begin
                exp_active = 1'b0; exp_done = 1'b1;
            end
        end
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    always @(posedge stretch_out) t_rise = $realtime;

    always @(negedge clk) begin
        checks++;
        if (stretch_out !== exp_done || eoc !== exp_done) begin
            fails++;
            $display("FAIL %s cycle check at %0t: actual out=%b eoc=%b expected %b (R8)",
                     tag, $realtime, stretch_out, eoc, exp_done);
        end
    end

    task automatic check_real(input string req, input real act, input real exp);
        checks++;
        if (act < exp - 0.01 || act > exp + 0.01) begin
            fails++;
            $display("FAIL %s: actual %0.2f expected %0.2f", req, act, exp);
        end
    endtask

    task automatic set_period(input real p);
        period = p;
        repeat (3) @(negedge clk);
    endtask

    task automatic convert(input int c, output real dly);
        @(negedge clk);
        start = 1'b1; code = CODE_W'(c);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < c + 4 && !stretch_out; i++) @(negedge clk);
        dly = stretch_out ? (t_rise - t_start) : -1.0;
    endtask

    initial begin
        real d, d_small, d_big;
        repeat (3) @(negedge clk);
        tag = "R1";
        checks++;
        if (stretch_out !== 1'b0 || eoc !== 1'b0) begin
            fails++;
            $display("FAIL R1: actual out=%b eoc=%b expected 0 0", stretch_out, eoc);
        end
        rst = 1'b0;
        tag = "R9";
        repeat (8) @(negedge clk);

        tag = "R2";
        convert(5, d); check_real("R2 code 5 at 25ns", d, 5 * period);
        tag = "R4";
        repeat (10) @(negedge clk);
        checks++;
        if (stretch_out !== 1'b1) begin
            fails++;
            $display("FAIL R4 hold: actual %b expected 1", stretch_out);
        end

        tag = "R3";
        convert(0, d); check_real("R3 code 0", d, period);
        convert(1, d); check_real("R3 code 1", d, period);

        tag = "R6";
        set_period(40.0);
        convert(3, d_small);  check_real("R2 code 3 at 40ns", d_small, 3 * period);
        convert(12, d_big);   check_real("R2 code 12 at 40ns", d_big, 12 * period);
        checks++;
        if (!(d_big > d_small)) begin
            fails++;
            $display("FAIL R6: actual %0.2f expected > %0.2f", d_big, d_small);
        end

        tag = "R5";
        set_period(30.0);
        @(negedge clk); start = 1'b1; code = CODE_W'(20);
        @(negedge clk); start = 1'b0;
        repeat (6) @(negedge clk);
        convert(4, d); check_real("R5 restart code 4", d, 4 * period);

        tag = "R2";
        set_period(17.0);
        convert(9, d); check_real("R2 code 9 at 17ns", d, 9 * period);

        tag = "R7";
        set_period(10.0);
        convert((1 << CODE_W) - 1, d);
        check_real("R7 full scale", d, real'((1 << CODE_W) - 1) * period);

        tag = "R4";
        repeat (2) @(negedge clk);
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule